// File: doc/BRIEF.md
# Tag-Renaming Register File

This block is the architectural register file of a dynamically scheduled core. Each entry holds either a finished data word or the tag of the reservation station that will later produce that word. When an instruction is dispatched, the block returns both source operands as value-or-tag pairs. It then renames the destination register to the tag of the station allocated to the instruction. It also splits the instruction word into its opcode, destination and source fields, and flags the halt opcode.

Several execution units send results back on independent broadcast buses, each result carrying a producer tag. A register takes a broadcast value only while it is still waiting on exactly that tag. A register that has since been renamed to a newer producer ignores the older result.

A read whose source matches a broadcast arriving in the same cycle returns the broadcast value. The consumer therefore never latches a tag that is about to become stale. All state changes on the rising clock edge, and reads are combinational from the current state.

Top module: `tag_rename_regfile`

## Requirements
- R1: After reset every register reads as data value 5 with its pending flag at 0.
- R2: The instruction word is decoded as opcode in bits [31:28], destination index in [27:24], source A index in [23:20] and source B index in [19:16]. Bits [15:0] have no effect on any output or on any state.
- R3: A source that names a non-pending register returns pending 0 and that register's 32-bit value.
- R4: A dispatch (disp_valid_i high, opcode not 4'hF) marks the destination pending from the next rising edge. A read of that register then returns pending 1, with the station tag in data bits [1:0] and zeros above them.
- R5: During the cycle of a dispatch, its sources read the mapping from before the rename, including a source that equals the destination.
- R6: A valid broadcast whose tag equals the tag of a pending register writes the broadcast data into that register at the next rising edge and clears its pending flag.
- R7: A broadcast with a non-matching tag leaves a pending register unchanged. A broadcast never alters a non-pending register, even when that register's low value bits equal the broadcast tag.
- R8: A register renamed to a newer tag is not written by a broadcast of its older tag.
- R9: When a source names a pending register and a valid broadcast carries that register's tag in the same cycle, the read returns pending 0 and the broadcast data.
- R10: Opcode 4'hF raises halt_o and renames no register, even with disp_valid_i high.
- R11: If a dispatch renames a register in the same cycle that a broadcast matches that register's old tag, the rename wins and the register stays pending on the new tag.
- R12: All three buses are independent. Bus k carries its tag in bus_tag_i[2k+1:2k] and its data in bus_data_i[32k+31:32k], and distinct tags on different buses update different registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 32 | Instruction word being dispatched or inspected |
| disp_valid_i | input | 1 | Dispatch this cycle (rename the destination) |
| disp_tag_i | input | 2 | Reservation station allocated to the dispatched instruction |
| bus_valid_i | input | 3 | One valid bit per result bus |
| bus_tag_i | input | 6 | Producer tag of each bus, 2 bits per bus |
| bus_data_i | input | 96 | Result data of each bus, 32 bits per bus |
| opcode_o | output | 4 | Decoded opcode |
| dest_o | output | 4 | Decoded destination index |
| src_a_o | output | 4 | Decoded source A index |
| src_b_o | output | 4 | Decoded source B index |
| halt_o | output | 1 | Opcode is the halt code 4'hF |
| a_pending_o | output | 1 | Source A holds a tag rather than a value |
| a_data_o | output | 32 | Source A value, or tag zero-extended |
| b_pending_o | output | 1 | Source B holds a tag rather than a value |
| b_data_o | output | 32 | Source B value, or tag zero-extended |

## Verification
The bench builds the block with its default parameters: 16 registers of 32 bits, 2-bit tags, three buses and same-cycle forwarding enabled. With only four tags, the reset value 5 has low bits that alias tag 1. This makes it possible to check that a ready register ignores a broadcast whose tag happens to match its value bits. Three buses allow all of them to fire in one cycle, which covers simultaneous wakeups and the case where a newer rename races an older result.

// File: rtl/trrf_pkg.sv
package trrf_pkg;
   typedef enum logic [3:0] {
      OPC_ADD  = 4'h0,
      OPC_SUB  = 4'h1,
      OPC_MUL  = 4'h2,
      OPC_DIV  = 4'h3,
      OPC_HALT = 4'hF
   } opcode_e;

   localparam int OPC_W = 4;
endpackage

// File: rtl/trrf_decode.sv
module trrf_decode #(
   parameter int INSTR_W = 32,
   parameter int OPC_W   = 4,
   parameter int IDX_W   = 4,
   parameter logic [OPC_W-1:0] HALT_CODE = '1
) (
   input  logic [INSTR_W-1:0] instr,
   output logic [OPC_W-1:0]   opcode,
   output logic [IDX_W-1:0]   dest,
   output logic [IDX_W-1:0]   src_a,
   output logic [IDX_W-1:0]   src_b,
   output logic               is_halt
);
   localparam int OP_HI   = INSTR_W - 1;
   localparam int DST_HI  = OP_HI - OPC_W;
   localparam int SRCA_HI = DST_HI - IDX_W;
   localparam int SRCB_HI = SRCA_HI - IDX_W;

   if (INSTR_W < OPC_W + 3*IDX_W) begin : g_bad_width
      $error("trrf_decode: instruction word too narrow for its fields");
   end

   always_comb begin
      opcode  = instr[OP_HI   -: OPC_W];
      dest    = instr[DST_HI  -: IDX_W];
      src_a   = instr[SRCA_HI -: IDX_W];
      src_b   = instr[SRCB_HI -: IDX_W];
      is_halt = (opcode == HALT_CODE);
   end
endmodule

// File: rtl/trrf_bus_match.sv
module trrf_bus_match #(
   parameter int NUM_BUS = 3,
   parameter int TAG_W   = 2,
   parameter int DATA_W  = 32
) (
   input  logic                           pending,
   input  logic [TAG_W-1:0]               tag,
   input  logic [NUM_BUS-1:0]             bus_valid,
   input  logic [NUM_BUS-1:0][TAG_W-1:0]  bus_tag,
   input  logic [NUM_BUS-1:0][DATA_W-1:0] bus_data,
   output logic                           hit,
   output logic [DATA_W-1:0]              data
);
   logic [NUM_BUS-1:0] match;

   for (genvar b = 0; b < NUM_BUS; b++) begin : g_cmp
      assign match[b] = pending && bus_valid[b] && (bus_tag[b] == tag);
   end

   always_comb begin
      hit  = |match;
      data = '0;
      for (int b = NUM_BUS-1; b >= 0; b--) begin
         if (match[b]) data = bus_data[b];
      end
   end
endmodule

// File: rtl/trrf_read_port.sv
module trrf_read_port #(
   parameter int NUM_REGS  = 16,
   parameter int DATA_W    = 32,
   parameter int IDX_W     = 4,
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic [IDX_W-1:0]                idx,
   input  logic [NUM_REGS-1:0]             flag,
   input  logic [NUM_REGS-1:0][DATA_W-1:0] val,
   input  logic [NUM_REGS-1:0]             hit,
   input  logic [NUM_REGS-1:0][DATA_W-1:0] hit_data,
   output logic                            pending,
   output logic [DATA_W-1:0]               data
);
   logic              sel_flag;
   logic [DATA_W-1:0] sel_val;

   assign sel_flag = flag[idx];
   assign sel_val  = val[idx];

   if (BYPASS_EN) begin : g_bypass
      always_comb begin
         if (hit[idx]) begin
            pending = 1'b0;
            data    = hit_data[idx];
         end else begin
            pending = sel_flag;
            data    = sel_val;
         end
      end
   end else begin : g_plain
      logic unused_hit;
      assign unused_hit = ^{hit, hit_data};
      assign pending    = sel_flag;
      assign data       = sel_val;
   end
endmodule

// File: rtl/tag_rename_regfile.sv
module tag_rename_regfile
   import trrf_pkg::*;
#(
   parameter int NUM_REGS  = 16,
   parameter int DATA_W    = 32,
   parameter int TAG_W     = 2,
   parameter int NUM_BUS   = 3,
   parameter int INSTR_W   = 32,
   parameter logic [DATA_W-1:0] RESET_VAL = 32'd5,
   parameter bit BYPASS_EN = 1'b1,
   localparam int IDX_W    = $clog2(NUM_REGS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [INSTR_W-1:0]          instr_i,
   input  logic                        disp_valid_i,
   input  logic [TAG_W-1:0]            disp_tag_i,
   input  logic [NUM_BUS-1:0]          bus_valid_i,
   input  logic [NUM_BUS*TAG_W-1:0]    bus_tag_i,
   input  logic [NUM_BUS*DATA_W-1:0]   bus_data_i,
   output logic [OPC_W-1:0]            opcode_o,
   output logic [IDX_W-1:0]            dest_o,
   output logic [IDX_W-1:0]            src_a_o,
   output logic [IDX_W-1:0]            src_b_o,
   output logic                        halt_o,
   output logic                        a_pending_o,
   output logic [DATA_W-1:0]           a_data_o,
   output logic                        b_pending_o,
   output logic [DATA_W-1:0]           b_data_o
);
   if (TAG_W > DATA_W) begin : g_bad_tag
      $error("tag_rename_regfile: tag wider than data word");
   end
   if (NUM_REGS != (1 << IDX_W)) begin : g_bad_regs
      $error("tag_rename_regfile: register count must be a power of two");
   end
   if (NUM_BUS < 1) begin : g_bad_bus
      $error("tag_rename_regfile: at least one result bus required");
   end

   logic [NUM_BUS-1:0][TAG_W-1:0]  bus_tag;
   logic [NUM_BUS-1:0][DATA_W-1:0] bus_data;

   for (genvar b = 0; b < NUM_BUS; b++) begin : g_unpack
      assign bus_tag[b]  = bus_tag_i[b*TAG_W +: TAG_W];
      assign bus_data[b] = bus_data_i[b*DATA_W +: DATA_W];
   end

   logic is_halt;

   trrf_decode #(
      .INSTR_W  (INSTR_W),
      .OPC_W    (OPC_W),
      .IDX_W    (IDX_W),
      .HALT_CODE(OPC_HALT)
   ) u_decode (
      .instr  (instr_i),
      .opcode (opcode_o),
      .dest   (dest_o),
      .src_a  (src_a_o),
      .src_b  (src_b_o),
      .is_halt(is_halt)
   );

   assign halt_o = is_halt;

   logic disp_fire;
   assign disp_fire = disp_valid_i && !is_halt;

   logic [NUM_REGS-1:0]             flag_q;
   logic [NUM_REGS-1:0][DATA_W-1:0] val_q;
   logic [NUM_REGS-1:0]             ren;
   logic [NUM_REGS-1:0]             hit;
   logic [NUM_REGS-1:0][DATA_W-1:0] hit_data;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      assign ren[i] = disp_fire && (dest_o == IDX_W'(i));

      trrf_bus_match #(
         .NUM_BUS(NUM_BUS),
         .TAG_W  (TAG_W),
         .DATA_W (DATA_W)
      ) u_match (
         .pending  (flag_q[i]),
         .tag      (val_q[i][TAG_W-1:0]),
         .bus_valid(bus_valid_i),
         .bus_tag  (bus_tag),
         .bus_data (bus_data),
         .hit      (hit[i]),
         .data     (hit_data[i])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flag_q[i] <= 1'b0;
            val_q[i]  <= RESET_VAL;
         end else if (ren[i]) begin
            flag_q[i] <= 1'b1;
            val_q[i]  <= DATA_W'(disp_tag_i);
         end else if (hit[i]) begin
            flag_q[i] <= 1'b0;
            val_q[i]  <= hit_data[i];
         end
      end

      assert_rename_R4: assert property (@(posedge clk) disable iff (!rst_n)
         ren[i] |=> flag_q[i] && (val_q[i] == DATA_W'($past(disp_tag_i))));

      assert_rename_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (ren[i] && hit[i]) |=> flag_q[i]);

      assert_writeback_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (hit[i] && !ren[i]) |=> !flag_q[i] && (val_q[i] == $past(hit_data[i])));

      assert_ready_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (!flag_q[i] && !ren[i]) |=> !flag_q[i] && $stable(val_q[i]));

      assert_wait_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_q[i] && !hit[i] && !ren[i]) |=> flag_q[i] && $stable(val_q[i]));
   end

   for (genvar a = 0; a < NUM_BUS; a++) begin : g_busa
      for (genvar c = a + 1; c < NUM_BUS; c++) begin : g_busc
         assert_bus_tags_unique_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_valid_i[a] && bus_valid_i[c]) |-> (bus_tag[a] != bus_tag[c]));
      end
   end

   assert_halt_no_rename_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid_i && is_halt) |=> ((flag_q & ~$past(flag_q)) == '0));

   trrf_read_port #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (DATA_W),
      .IDX_W    (IDX_W),
      .BYPASS_EN(BYPASS_EN)
   ) u_port_a (
      .idx     (src_a_o),
      .flag    (flag_q),
      .val     (val_q),
      .hit     (hit),
      .hit_data(hit_data),
      .pending (a_pending_o),
      .data    (a_data_o)
   );

   trrf_read_port #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (DATA_W),
      .IDX_W    (IDX_W),
      .BYPASS_EN(BYPASS_EN)
   ) u_port_b (
      .idx     (src_b_o),
      .flag    (flag_q),
      .val     (val_q),
      .hit     (hit),
      .hit_data(hit_data),
      .pending (b_pending_o),
      .data    (b_data_o)
   );
endmodule

// File: tb/tag_rename_regfile_tb_top.sv
module tag_rename_regfile_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] instr;
   logic        dv;
   logic [1:0]  dtag;
   logic [2:0]  bv;
   logic [5:0]  bt;
   logic [95:0] bd;
   logic [3:0]  opcode, dest, sa, sb;
   logic        halt, ap, bp;
   logic [31:0] ad, bdat;

   always #10 clk = ~clk;

   tag_rename_regfile dut_i (
      .clk(clk), .rst_n(rst_n), .instr_i(instr), .disp_valid_i(dv),
      .disp_tag_i(dtag), .bus_valid_i(bv), .bus_tag_i(bt), .bus_data_i(bd),
      .opcode_o(opcode), .dest_o(dest), .src_a_o(sa), .src_b_o(sb),
      .halt_o(halt), .a_pending_o(ap), .a_data_o(ad),
      .b_pending_o(bp), .b_data_o(bdat)
   );

   typedef struct {
      string       req;
      logic        p1;
      logic [31:0] d1;
      logic        p2;
      logic [31:0] d2;
   } exp_t;

   exp_t q[$];
   event sample_ev;
   int   n_chk  = 0;
   int   n_fail = 0;
   bit   done   = 0;

   function automatic logic [31:0] mk(input logic [3:0] op, input logic [3:0] d,
                                      input logic [3:0] s1, input logic [3:0] s2,
                                      input logic [15:0] low);
      return {op, d, s1, s2, low};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Driver: apply one cycle of stimulus and queue the expected operands.
   task automatic step(input logic [31:0] ins, input logic v, input logic [1:0] tg,
                       input logic [2:0] bvv, input logic [5:0] btv, input logic [95:0] bdv,
                       input string req, input logic e1p, input logic [31:0] e1d,
                       input logic e2p, input logic [31:0] e2d);
      exp_t e;
      instr = ins; dv = v; dtag = tg; bv = bvv; bt = btv; bd = bdv;
      e.req = req; e.p1 = e1p; e.d1 = e1d; e.p2 = e2p; e.d2 = e2d;
      q.push_back(e);
      #5;
      ->sample_ev;
      @(negedge clk);
   endtask

   // Monitor: pop expected items and compare with the ports.
   initial begin
      forever begin
         @(sample_ev);
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk({e.req, " srcA pending"}, {31'd0, ap}, {31'd0, e.p1});
            chk({e.req, " srcA data"},    ad,          e.d1);
            chk({e.req, " srcB pending"}, {31'd0, bp}, {31'd0, e.p2});
            chk({e.req, " srcB data"},    bdat,        e.d2);
         end
      end
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; instr = '0; dv = 1'b0; dtag = '0; bv = '0; bt = '0; bd = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R2 decode, including ignored low bits
      instr = mk(4'h2, 4'h1, 4'h6, 4'hC, 16'hBEEF);
      #5;
      chk("R2 opcode", {28'd0, opcode}, 32'h2);
      chk("R2 dest",   {28'd0, dest},   32'h1);
      chk("R2 srcA",   {28'd0, sa},     32'h6);
      chk("R2 srcB",   {28'd0, sb},     32'hC);
      chk("R10 halt low for non-halt opcode", {31'd0, halt}, 32'd0);
      @(negedge clk);

      // R1 / R3 reset values
      step(mk(4'h0, 4'h0, 4'h3, 4'h7, 16'h0), 0, 2'd0, 3'b000, 6'd0, 96'd0,
           "R1 R3 reset read", 0, 32'd5, 0, 32'd5);
      // R5 dispatch r1 <- r1,r2 tag 2; R2 low bits set
      step(mk(4'h0, 4'h1, 4'h1, 4'h2, 16'hABCD), 1, 2'd2, 3'b000, 6'd0, 96'd0,
           "R5 R2 old mapping in dispatch cycle", 0, 32'd5, 0, 32'd5);
      step(mk(4'h0, 4'h0, 4'h1, 4'h2, 16'h0), 0, 2'd0, 3'b000, 6'd0, 96'd0,
           "R4 renamed dest reads tag", 1, 32'd2, 0, 32'd5);
      // R7 mismatching tag 1 on bus0; r3 holds 5 whose low bits equal 1
      step(mk(4'h0, 4'h0, 4'h1, 4'h3, 16'h0), 0, 2'd0, 3'b001, {2'd0, 2'd0, 2'd1},
           {32'd0, 32'd0, 32'd99}, "R7 mismatch broadcast cycle", 1, 32'd2, 0, 32'd5);
      step(mk(4'h0, 4'h0, 4'h1, 4'h3, 16'h0), 0, 2'd0, 3'b000, 6'd0, 96'd0,
           "R7 after mismatch broadcast", 1, 32'd2, 0, 32'd5);
      // R9 forwarding on bus1 tag 2
      step(mk(4'h0, 4'h0, 4'h1, 4'h1, 16'h0), 0, 2'd0, 3'b010, {2'd0, 2'd2, 2'd0},
           {32'd0, 32'd1234, 32'd0}, "R9 same-cycle forward", 0, 32'd1234, 0, 32'd1234);
      step(mk(4'h0, 4'h0, 4'h1, 4'h4, 16'h0), 0, 2'd0, 3'b000, 6'd0, 96'd0,
           "R6 written and cleared", 0, 32'd1234, 0, 32'd5);
      // R8 double rename of r5
      step(mk(4'h2, 4'h5, 4'h6, 4'h7, 16'h0), 1, 2'd0, 3'b000, 6'd0, 96'd0,
           "R3 first rename r5", 0, 32'd5, 0, 32'd5);
      step(mk(4'h2, 4'h5, 4'h5, 4'h6, 16'h0), 1, 2'd3, 3'b000, 6'd0, 96'd0,
           "R4 second rename r5 reads tag 0", 1, 32'd0, 0, 32'd5);
      step(mk(4'h0, 4'h0, 4'h5, 4'h8, 16'h0), 0, 2'd0, 3'b100, {2'd0, 2'd0, 2'd0},
           {32'd777, 32'd0, 32'd0}, "R8 older tag broadcast cycle", 1, 32'd3, 0, 32'd5);
      step(mk(4'h0, 4'h0, 4'h5, 4'h5, 16'h0), 0, 2'd0, 3'b000, 6'd0, 96'd0,
           "R8 renamed reg untouched", 1, 32'd3, 1, 32'd3);
      // R10 halt with valid dispatch
      instr = mk(4'hF, 4'h9, 4'h9, 4'hA, 16'h0); dv = 1'b1; dtag = 2'd1;
      #5;
      chk("R10 halt flagged", {31'd0, halt}, 32'd1);
      @(negedge clk);
      step(mk(4'h0, 4'h0, 4'h9, 4'hA, 16'h0), 0, 2'd0, 3'b000, 6'd0, 96'd0,
           "R10 halt renamed nothing", 0, 32'd5, 0, 32'd5);
      // R11 rename racing older result
      step(mk(4'h1, 4'hA, 4'hB, 4'hB, 16'h0), 1, 2'd1, 3'b000, 6'd0, 96'd0,
           "R3 rename r10 tag 1", 0, 32'd5, 0, 32'd5);
      step(mk(4'h1, 4'hA, 4'hA, 4'hB, 16'h0), 1, 2'd2, 3'b001, {2'd0, 2'd0, 2'd1},
           {32'd0, 32'd0, 32'd55}, "R9 R11 forward during rename", 0, 32'd55, 0, 32'd5);
      step(mk(4'h0, 4'h0, 4'hA, 4'hB, 16'h0), 0, 2'd0, 3'b000, 6'd0, 96'd0,
           "R11 rename wins", 1, 32'd2, 0, 32'd5);
      // R12 three buses at once
      step(mk(4'h3, 4'hC, 4'h0, 4'h0, 16'h0), 1, 2'd0, 3'b000, 6'd0, 96'd0,
           "R3 rename r12 tag 0", 0, 32'd5, 0, 32'd5);
      step(mk(4'h3, 4'hD, 4'hC, 4'h0, 16'h0), 1, 2'd1, 3'b000, 6'd0, 96'd0,
           "R4 rename r13 tag 1", 1, 32'd0, 0, 32'd5);
      step(mk(4'h0, 4'h0, 4'hC, 4'hD, 16'h0), 0, 2'd0, 3'b111, {2'd3, 2'd1, 2'd0},
           {32'd300, 32'd200, 32'd100}, "R12 R9 three-bus forward", 0, 32'd100, 0, 32'd200);
      step(mk(4'h0, 4'h0, 4'hC, 4'hD, 16'h0), 0, 2'd0, 3'b000, 6'd0, 96'd0,
           "R12 R6 bus0 bus1 written", 0, 32'd100, 0, 32'd200);
      step(mk(4'h0, 4'h0, 4'h5, 4'hA, 16'h0), 0, 2'd0, 3'b000, 6'd0, 96'd0,
           "R12 bus2 written, r10 still waits", 0, 32'd300, 1, 32'd2);

      #1;
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule